// File: doc/BRIEF.md
# Serial Configuration Write Port for a Dual Synthesizer Core

This block takes configuration words over a three-wire serial link (serial clock, serial data and a load strobe) and turns them into the static control fields of a two-sided frequency synthesizer core. Bits enter a 22-bit input register most significant bit first, one per rising serial clock. A rising edge on the load strobe then copies the word into one of four configuration latches. The two lowest word bits pick the latch. Each side has one reference latch and one divider latch.

The block also runs the power-down of each side. If a side's charge pump is driving when power-down is requested, the pump is three-stated for one core clock cycle before the power-down flag rises. If the pump is already three-stated, power-down takes effect on the same load. The latches stay writable while a side is down. The block keeps every output inactive until all four latches have been loaded once after reset. All three serial lines are resynchronised to the core clock.

Top module: `sercfg_top`

## Requirements
- R1: After reset all four latches hold zero, `active` is 0, both `sX_pd` are 0, both `sX_cp_hiz` and both `sX_div_hold` are 1, and `osc_en` is 0.
- R2: The input register keeps the last 22 bits seen on rising serial clock edges, oldest at bit 21. When more than 22 bits are shifted before a load, the earliest bits drop out.
- R3: On a load, word bits [1:0] choose the destination: 00 side-2 reference, 01 side-2 divider, 10 side-1 reference, 11 side-1 divider. The other three latches keep their contents. Reference latch fields: R divider [15:2], polarity 16, pump three-state 17, pump current 18, mux select [20:19]. Divider latch fields: A count [7:2], B count [18:8], prescaler select 19, power-down 20. Bit 21 is spare in both. `mux_sel` is {side-1 mux bits, side-2 mux bits}.
- R4: Only a rising edge of the load strobe transfers the word. Shifting with the strobe low, or with it held high, leaves every latch unchanged.
- R5: A side's power-down is requested by writing 1 to its power-down bit while its latched pump three-state bit is 0. On that load, `sX_cp_hiz` rises in the same core cycle in which the latch updates, and `sX_pd` rises one core cycle later.
- R6: A side's power-down is requested by writing 1 while its latched pump three-state bit is 1. On that load, `sX_pd` rises in the same core cycle in which the latch updates.
- R7: While a side is powered down, its `sX_div_hold` is 1 (its dividers are held in their load state).
- R8: `osc_en` is 0 only when both sides are powered down or `active` is 0. It is 1 when only one side is down.
- R9: Loads are accepted while a side is powered down. Loading 0 into the power-down bit clears `sX_pd` in the same cycle as the latch update, and `sX_cp_hiz` then follows the latched three-state bit.
- R10: `active` rises only once each of the four latches has been loaded at least once since reset. While `active` is 0, every pump is three-stated and every divider is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe, transfers on its rising edge |
| s1_r_div | output | 14 | Side-1 reference divider value |
| s1_a_cnt | output | 6 | Side-1 swallow (A) count |
| s1_b_cnt | output | 11 | Side-1 main (B) count |
| s1_pol | output | 1 | Side-1 phase detector polarity |
| s1_cp_cur | output | 1 | Side-1 pump current select |
| s1_prescale | output | 1 | Side-1 prescaler modulus select |
| s1_cp_hiz | output | 1 | Side-1 pump three-state (effective) |
| s1_pd | output | 1 | Side-1 powered down |
| s1_div_hold | output | 1 | Side-1 dividers held in load state |
| s2_r_div | output | 14 | Side-2 reference divider value |
| s2_a_cnt | output | 6 | Side-2 swallow (A) count |
| s2_b_cnt | output | 11 | Side-2 main (B) count |
| s2_pol | output | 1 | Side-2 phase detector polarity |
| s2_cp_cur | output | 1 | Side-2 pump current select |
| s2_prescale | output | 1 | Side-2 prescaler modulus select |
| s2_cp_hiz | output | 1 | Side-2 pump three-state (effective) |
| s2_pd | output | 1 | Side-2 powered down |
| s2_div_hold | output | 1 | Side-2 dividers held in load state |
| mux_sel | output | 4 | Output multiplexer select, side-1 bits high |
| osc_en | output | 1 | Reference oscillator enable |
| active | output | 1 | All four latches loaded since reset |

## Verification
Words are sent to every destination code with distinct field values, so a routing or field-position slip shows up as a mismatch in a neighbouring latch. An over-long bit train and shifting with no strobe edge separate correct windowing and edge detection from level-sensitive loading. Power-down is requested once with the pump driving and once with it already three-stated, which tells the one-cycle-delayed sequence apart from the immediate one. The oscillator enable is watched with one side down and then with both down. A reload while a side is down, followed by a power-up word, confirms that the latches stay live and that wake-up takes effect at once.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int WORD_W    = 22;
  localparam int CTRL_W    = 2;
  localparam int NUM_LATCH = 4;
  localparam int LAT_W     = WORD_W - CTRL_W;
  localparam int R_W       = 14;
  localparam int A_W       = 6;
  localparam int B_W       = 11;
  localparam int MUX_W     = 2;
  localparam int SYNC_N    = 2;

  // payload positions (payload bit p is word bit p + CTRL_W)
  localparam int R_LSB     = 0;
  localparam int POL_BIT   = R_LSB + R_W;
  localparam int TRI_BIT   = POL_BIT + 1;
  localparam int CUR_BIT   = TRI_BIT + 1;
  localparam int MUX_LSB   = CUR_BIT + 1;
  localparam int A_LSB     = 0;
  localparam int B_LSB     = A_LSB + A_W;
  localparam int PSC_BIT   = B_LSB + B_W;
  localparam int PD_BIT    = PSC_BIT + 1;
  localparam int SPARE_BIT = LAT_W - 1;

  typedef enum logic [1:0] {
    DST_S2_REF = 2'b00,
    DST_S2_DIV = 2'b01,
    DST_S1_REF = 2'b10,
    DST_S1_DIV = 2'b11
  } dest_e;

  typedef enum logic [1:0] {
    PWR_UP   = 2'b00,
    PWR_ARM  = 2'b01,
    PWR_DOWN = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/sercfg_frontend.sv
module sercfg_frontend #(
  parameter int WORD_W = sercfg_pkg::WORD_W,
  parameter int SYNC_N = sercfg_pkg::SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  localparam int HIST = SYNC_N + 1;

  logic [HIST-1:0]   ck_q, dt_q, le_q;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              ck_rise, data_s;

  assign ck_rise = ck_q[SYNC_N-1] & ~ck_q[SYNC_N];
  assign data_s  = dt_q[SYNC_N-1];
  assign load_o  = le_q[SYNC_N-1] & ~le_q[SYNC_N];
  assign word_o  = sh_q;

  always_comb begin
    sh_d = sh_q;
    if (ck_rise) sh_d = {sh_q[WORD_W-2:0], data_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      dt_q <= '0;
      le_q <= '0;
      sh_q <= '0;
    end else begin
      ck_q <= {ck_q[HIST-2:0], ser_clk};
      dt_q <= {dt_q[HIST-2:0], ser_data};
      le_q <= {le_q[HIST-2:0], ser_le};
      sh_q <= sh_d;
    end
  end

  p_shift_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ck_rise |=> (sh_q[0] == $past(data_s)));
endmodule

// File: rtl/sercfg_latch_bank.sv
module sercfg_latch_bank #(
  parameter int WORD_W    = sercfg_pkg::WORD_W,
  parameter int CTRL_W    = sercfg_pkg::CTRL_W,
  parameter int NUM_LATCH = sercfg_pkg::NUM_LATCH
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [WORD_W-1:0]                          word_i,
  input  logic                                       load_i,
  output logic [NUM_LATCH-1:0]                       wr_en_o,
  output logic [NUM_LATCH-1:0][WORD_W-CTRL_W-1:0]    lat_o,
  output logic                                       all_written_o
);
  localparam int LAT_W = WORD_W - CTRL_W;

  logic [NUM_LATCH-1:0][LAT_W-1:0] lat_q, lat_d;
  logic [NUM_LATCH-1:0]            seen_q, seen_d;
  logic [CTRL_W-1:0]               dst;

  assign dst = word_i[CTRL_W-1:0];

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    assign wr_en_o[i] = load_i && (dst == CTRL_W'(i));

    always_comb begin
      lat_d[i]  = lat_q[i];
      seen_d[i] = seen_q[i];
      if (wr_en_o[i]) begin
        lat_d[i]  = word_i[WORD_W-1:CTRL_W];
        seen_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q[i]  <= '0;
        seen_q[i] <= 1'b0;
      end else begin
        lat_q[i]  <= lat_d[i];
        seen_q[i] <= seen_d[i];
      end
    end
  end

  assign lat_o         = lat_q;
  assign all_written_o = &seen_q;

  p_one_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_o));
  p_active_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    all_written_o |=> all_written_o);
  p_hold_without_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(lat_q));
endmodule

// File: rtl/sercfg_pwr_seq.sv
module sercfg_pwr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic pd_bit_i,
  input  logic tri_bit_i,
  output logic pd_o,
  output logic hiz_force_o
);
  import sercfg_pkg::*;

  pwr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (load_i) begin
      if (!pd_bit_i)                         st_d = PWR_UP;
      else if (st_q != PWR_UP || tri_bit_i)  st_d = PWR_DOWN;
      else                                   st_d = PWR_ARM;
    end else if (st_q == PWR_ARM) begin
      st_d = PWR_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PWR_UP;
    else        st_q <= st_d;
  end

  assign pd_o        = (st_q == PWR_DOWN);
  assign hiz_force_o = (st_q != PWR_UP);

  p_sync_hiz_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && pd_bit_i && !tri_bit_i && !hiz_force_o) |=> (hiz_force_o && !pd_o));
  p_sync_pd_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_force_o && !pd_o && !load_i) |=> pd_o);
  p_async_immediate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && pd_bit_i && tri_bit_i) |=> pd_o);
  p_wake_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !pd_bit_i) |=> (!pd_o && !hiz_force_o));
endmodule

// File: rtl/sercfg_top.sv
module sercfg_top (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  output logic [13:0] s1_r_div,
  output logic [5:0]  s1_a_cnt,
  output logic [10:0] s1_b_cnt,
  output logic        s1_pol,
  output logic        s1_cp_cur,
  output logic        s1_prescale,
  output logic        s1_cp_hiz,
  output logic        s1_pd,
  output logic        s1_div_hold,
  output logic [13:0] s2_r_div,
  output logic [5:0]  s2_a_cnt,
  output logic [10:0] s2_b_cnt,
  output logic        s2_pol,
  output logic        s2_cp_cur,
  output logic        s2_prescale,
  output logic        s2_cp_hiz,
  output logic        s2_pd,
  output logic        s2_div_hold,
  output logic [3:0]  mux_sel,
  output logic        osc_en,
  output logic        active
);
  import sercfg_pkg::*;

  localparam int SIDES = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [WORD_W-1:0]                word;
  logic                             load;
  logic [NUM_LATCH-1:0]             wr_en;
  logic [NUM_LATCH-1:0][LAT_W-1:0]  lat;
  logic                             all_written;

  sercfg_frontend #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_front (
    .clk(clk), .rst_n(rst_ni),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .word_o(word), .load_o(load)
  );

  sercfg_latch_bank #(.WORD_W(WORD_W), .CTRL_W(CTRL_W), .NUM_LATCH(NUM_LATCH)) u_bank (
    .clk(clk), .rst_n(rst_ni),
    .word_i(word), .load_i(load),
    .wr_en_o(wr_en), .lat_o(lat), .all_written_o(all_written)
  );

  logic [SIDES-1:0]            pd_v, hiz_v, pol_v, cur_v, psc_v, tri_v;
  logic [SIDES-1:0][R_W-1:0]   rdiv_v;
  logic [SIDES-1:0][A_W-1:0]   a_v;
  logic [SIDES-1:0][B_W-1:0]   b_v;
  logic [SIDES-1:0][MUX_W-1:0] mux_v;

  // side index 0 is side 1 (destinations 10/11), index 1 is side 2 (00/01)
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int RI = (s == 0) ? int'(DST_S1_REF) : int'(DST_S2_REF);
    localparam int DI = (s == 0) ? int'(DST_S1_DIV) : int'(DST_S2_DIV);

    assign rdiv_v[s] = lat[RI][R_LSB +: R_W];
    assign pol_v[s]  = lat[RI][POL_BIT];
    assign tri_v[s]  = lat[RI][TRI_BIT];
    assign cur_v[s]  = lat[RI][CUR_BIT];
    assign mux_v[s]  = lat[RI][MUX_LSB +: MUX_W];
    assign a_v[s]    = lat[DI][A_LSB +: A_W];
    assign b_v[s]    = lat[DI][B_LSB +: B_W];
    assign psc_v[s]  = lat[DI][PSC_BIT];

    sercfg_pwr_seq u_pwr (
      .clk(clk), .rst_n(rst_ni),
      .load_i(wr_en[DI]),
      .pd_bit_i(word[CTRL_W + PD_BIT]),
      .tri_bit_i(tri_v[s]),
      .pd_o(pd_v[s]),
      .hiz_force_o(hiz_v[s])
    );
  end

  logic unused_spare;
  assign unused_spare = ^{lat[0][SPARE_BIT], lat[1][SPARE_BIT],
                          lat[2][SPARE_BIT], lat[3][SPARE_BIT]};

  assign active      = all_written;

  assign s1_r_div    = rdiv_v[0];
  assign s1_a_cnt    = a_v[0];
  assign s1_b_cnt    = b_v[0];
  assign s1_pol      = pol_v[0];
  assign s1_cp_cur   = cur_v[0];
  assign s1_prescale = psc_v[0];
  assign s1_pd       = pd_v[0];
  assign s1_cp_hiz   = tri_v[0] | hiz_v[0] | ~all_written;
  assign s1_div_hold = pd_v[0] | ~all_written;

  assign s2_r_div    = rdiv_v[1];
  assign s2_a_cnt    = a_v[1];
  assign s2_b_cnt    = b_v[1];
  assign s2_pol      = pol_v[1];
  assign s2_cp_cur   = cur_v[1];
  assign s2_prescale = psc_v[1];
  assign s2_pd       = pd_v[1];
  assign s2_cp_hiz   = tri_v[1] | hiz_v[1] | ~all_written;
  assign s2_div_hold = pd_v[1] | ~all_written;

  assign mux_sel     = {mux_v[0], mux_v[1]};
  assign osc_en      = all_written & ~(pd_v[0] & pd_v[1]);

  p_down_holds_div_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(s1_pd) |-> s1_div_hold && s1_cp_hiz);
  p_inactive_safe_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !active |=> ($past(!active) && !active) |-> (s1_cp_hiz && s2_cp_hiz));
endmodule

// File: tb/tb_sercfg_top.sv
module tb_sercfg_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;

  logic [13:0] s1_r_div, s2_r_div;
  logic [5:0]  s1_a_cnt, s2_a_cnt;
  logic [10:0] s1_b_cnt, s2_b_cnt;
  logic s1_pol, s1_cp_cur, s1_prescale, s1_cp_hiz, s1_pd, s1_div_hold;
  logic s2_pol, s2_cp_cur, s2_prescale, s2_cp_hiz, s2_pd, s2_div_hold;
  logic [3:0] mux_sel;
  logic osc_en, active;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercfg_top dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .s1_r_div(s1_r_div), .s1_a_cnt(s1_a_cnt), .s1_b_cnt(s1_b_cnt), .s1_pol(s1_pol),
    .s1_cp_cur(s1_cp_cur), .s1_prescale(s1_prescale), .s1_cp_hiz(s1_cp_hiz),
    .s1_pd(s1_pd), .s1_div_hold(s1_div_hold),
    .s2_r_div(s2_r_div), .s2_a_cnt(s2_a_cnt), .s2_b_cnt(s2_b_cnt), .s2_pol(s2_pol),
    .s2_cp_cur(s2_cp_cur), .s2_prescale(s2_prescale), .s2_cp_hiz(s2_cp_hiz),
    .s2_pd(s2_pd), .s2_div_hold(s2_div_hold),
    .mux_sel(mux_sel), .osc_en(osc_en), .active(active)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // line latency: a value driven now is seen by the shift logic after two edges
  bit       ck_h[$], dt_h[$], le_h[$];
  bit [21:0] m_sr;
  bit [21:0] m_lat [4];
  bit        m_wr  [4];
  int        m_mode[2];   // 0 up, 1 pump three-stated awaiting power-down, 2 down

  function automatic void model_reset();
    ck_h = '{0, 0, 0}; dt_h = '{0, 0, 0}; le_h = '{0, 0, 0};
    m_sr = '0;
    foreach (m_lat[i]) begin m_lat[i] = '0; m_wr[i] = 0; end
    m_mode[0] = 0; m_mode[1] = 0;
  endfunction

  function automatic int ref_of(int s); return (s == 0) ? 2 : 0; endfunction

  function automatic void model_step(bit ck, bit dt, bit le);
    bit [21:0] nsr = m_sr;
    int nmode[2];
    nmode[0] = m_mode[0]; nmode[1] = m_mode[1];
    for (int s = 0; s < 2; s++) if (m_mode[s] == 1) nmode[s] = 2;
    if (ck_h[1] && !ck_h[2]) nsr = {m_sr[20:0], dt_h[1]};
    if (le_h[1] && !le_h[2]) begin
      int d = int'(m_sr[1:0]);
      int side = (d >= 2) ? 0 : 1;
      if (d == 1 || d == 3) begin
        if (!m_sr[20]) nmode[side] = 0;
        else if (m_mode[side] != 0 || m_lat[ref_of(side)][17]) nmode[side] = 2;
        else nmode[side] = 1;
      end
      m_lat[d] = m_sr;
      m_wr[d]  = 1;
    end
    m_sr = nsr;
    m_mode[0] = nmode[0]; m_mode[1] = nmode[1];
    ck_h.push_front(ck); void'(ck_h.pop_back());
    dt_h.push_front(dt); void'(dt_h.pop_back());
    le_h.push_front(le); void'(le_h.pop_back());
  endfunction

  function automatic bit m_active(); return m_wr[0] & m_wr[1] & m_wr[2] & m_wr[3]; endfunction

  task automatic compare_all();
    bit act = m_active();
    bit [21:0] r1 = m_lat[2], d1 = m_lat[3], r2 = m_lat[0], d2 = m_lat[1];
    chk(active == act, "R10 active", active, act);
    chk({s1_r_div, s1_pol, s1_cp_cur} == {r1[15:2], r1[16], r1[18]}, "R3 s1 reference fields",
        {s1_r_div, s1_pol, s1_cp_cur}, {r1[15:2], r1[16], r1[18]});
    chk({s1_a_cnt, s1_b_cnt, s1_prescale} == {d1[7:2], d1[18:8], d1[19]}, "R3 s1 divider fields",
        {s1_a_cnt, s1_b_cnt, s1_prescale}, {d1[7:2], d1[18:8], d1[19]});
    chk({s2_r_div, s2_pol, s2_cp_cur} == {r2[15:2], r2[16], r2[18]}, "R3 s2 reference fields",
        {s2_r_div, s2_pol, s2_cp_cur}, {r2[15:2], r2[16], r2[18]});
    chk({s2_a_cnt, s2_b_cnt, s2_prescale} == {d2[7:2], d2[18:8], d2[19]}, "R3 s2 divider fields",
        {s2_a_cnt, s2_b_cnt, s2_prescale}, {d2[7:2], d2[18:8], d2[19]});
    chk(mux_sel == {r1[20:19], r2[20:19]}, "R3 mux_sel", mux_sel, {r1[20:19], r2[20:19]});
    chk(s1_cp_hiz == (r1[17] | (m_mode[0] != 0) | !act), "R5 s1_cp_hiz", s1_cp_hiz,
        r1[17] | (m_mode[0] != 0) | !act);
    chk(s2_cp_hiz == (r2[17] | (m_mode[1] != 0) | !act), "R5 s2_cp_hiz", s2_cp_hiz,
        r2[17] | (m_mode[1] != 0) | !act);
    chk(s1_pd == (m_mode[0] == 2), "R6 s1_pd", s1_pd, m_mode[0] == 2);
    chk(s2_pd == (m_mode[1] == 2), "R6 s2_pd", s2_pd, m_mode[1] == 2);
    chk(s1_div_hold == ((m_mode[0] == 2) | !act), "R7 s1_div_hold", s1_div_hold,
        (m_mode[0] == 2) | !act);
    chk(s2_div_hold == ((m_mode[1] == 2) | !act), "R7 s2_div_hold", s2_div_hold,
        (m_mode[1] == 2) | !act);
    chk(osc_en == (act & !(m_mode[0] == 2 && m_mode[1] == 2)), "R8 osc_en", osc_en,
        act & !(m_mode[0] == 2 && m_mode[1] == 2));
  endtask

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      compare_all();
      model_step(ser_clk, ser_data, ser_le);
    end
  end

  // ---------------- stimulus ----------------
  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bits(input bit [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i]; ser_clk = 1'b0; hold(3);
      ser_clk = 1'b1; hold(3);
    end
    ser_clk = 1'b0; hold(3);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; hold(4);
    ser_le = 1'b0; hold(4);
  endtask

  task automatic send(input bit [21:0] w);
    shift_bits({10'b0, w}, 22);
    pulse_le();
  endtask

  function automatic bit [21:0] mk_ref(bit [13:0] r, bit pol, bit tri_b, bit cur, bit [1:0] mx, bit [1:0] d);
    return {1'b0, mx, cur, tri_b, pol, r, d};
  endfunction
  function automatic bit [21:0] mk_div(bit [5:0] a, bit [10:0] b, bit psc, bit pd, bit [1:0] d);
    return {1'b0, pd, psc, b, a, d};
  endfunction

  initial begin
    hold(3);
    chk(active == 1'b0 && s1_cp_hiz && s2_cp_hiz, "R1 reset outputs", {active, s1_cp_hiz, s2_cp_hiz}, 3'b011);
    chk(s1_pd == 0 && s2_pd == 0 && osc_en == 0 && s1_div_hold && s2_div_hold, "R1 reset power state",
        {s1_pd, s2_pd, osc_en, s1_div_hold, s2_div_hold}, 5'b00011);
    rst_n = 1'b1;
    hold(5);
    chk(s1_r_div == 0 && s2_b_cnt == 0 && mux_sel == 0, "R1 latches zero", s1_r_div, 0);

    // R3 / R10: three latches, then the fourth
    send(mk_ref(14'd50, 1'b1, 1'b0, 1'b1, 2'b01, 2'b00));
    send(mk_div(6'd13, 11'd405, 1'b0, 1'b0, 2'b01));
    send(mk_ref(14'h2A5B, 1'b0, 1'b0, 1'b0, 2'b10, 2'b10));
    chk(active == 1'b0, "R10 three latches only", active, 0);
    chk(s2_r_div == 14'd50 && s2_pol == 1'b1 && s2_cp_cur == 1'b1, "R3 side-2 reference", s2_r_div, 50);
    chk(s1_r_div == 14'h2A5B, "R3 side-1 reference", s1_r_div, 14'h2A5B);
    send(mk_div(6'd63, 11'd2047, 1'b1, 1'b0, 2'b11));
    chk(active == 1'b1 && osc_en == 1'b1, "R10 all four written", {active, osc_en}, 2'b11);
    chk(s1_a_cnt == 6'd63 && s1_b_cnt == 11'd2047 && s1_prescale, "R3 side-1 divider", s1_b_cnt, 2047);
    chk(s2_a_cnt == 6'd13 && s2_b_cnt == 11'd405, "R3 side-2 divider untouched", s2_b_cnt, 405);
    chk(mux_sel == 4'b1001, "R3 mux_sel packing", mux_sel, 4'b1001);

    // R2: 25 bits, the first three must fall out
    shift_bits({7'b0, 3'b111, mk_ref(14'd7, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00)}, 25);
    pulse_le();
    chk(s2_r_div == 14'd7 && mux_sel[1:0] == 2'b00, "R2 last 22 bits kept", s2_r_div, 7);

    // R4: shift without a load edge, and with the strobe held high
    shift_bits({10'b0, mk_ref(14'd999, 1'b1, 1'b1, 1'b1, 2'b11, 2'b10)}, 22);
    chk(s1_r_div == 14'h2A5B && s1_cp_hiz == 1'b0, "R4 no load without strobe edge", s1_r_div, 14'h2A5B);
    ser_le = 1'b1; hold(4);
    shift_bits({10'b0, mk_ref(14'd321, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00)}, 22);
    chk(s2_r_div == 14'd7, "R4 strobe held high loads nothing more", s2_r_div, 7);
    ser_le = 1'b0; hold(4);
    chk(s1_r_div == 14'd999, "R4 edge loaded the word present at the edge", s1_r_div, 999);
    send(mk_ref(14'h2A5B, 1'b0, 1'b0, 1'b0, 2'b10, 2'b10));

    // R5: side 1 pump driving -> synchronous power-down
    send(mk_div(6'd63, 11'd2047, 1'b1, 1'b1, 2'b11));
    chk(s1_pd && s1_cp_hiz && s1_div_hold, "R5 side-1 synchronous power-down", {s1_pd, s1_cp_hiz}, 2'b11);
    chk(osc_en == 1'b1, "R8 one side down keeps oscillator", osc_en, 1);

    // R6: side 2 pump three-stated first -> immediate power-down
    send(mk_ref(14'd7, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00));
    send(mk_div(6'd13, 11'd405, 1'b0, 1'b1, 2'b01));
    chk(s2_pd && s2_div_hold, "R6 side-2 asynchronous power-down", s2_pd, 1);
    chk(osc_en == 1'b0, "R8 both down stops oscillator", osc_en, 0);
    chk(s1_div_hold && s2_div_hold, "R7 dividers held", {s1_div_hold, s2_div_hold}, 2'b11);

    // R9: reload while down, then wake up
    send(mk_ref(14'd1234, 1'b1, 1'b0, 1'b0, 2'b01, 2'b10));
    chk(s1_r_div == 14'd1234 && s1_pd, "R9 load accepted while down", s1_r_div, 1234);
    send(mk_div(6'd5, 11'd100, 1'b0, 1'b0, 2'b11));
    chk(!s1_pd && !s1_cp_hiz && !s1_div_hold && s1_b_cnt == 11'd100, "R9 side-1 wakes",
        {s1_pd, s1_cp_hiz, s1_div_hold}, 3'b000);
    chk(osc_en == 1'b1, "R8 oscillator back with one side up", osc_en, 1);
    send(mk_div(6'd13, 11'd405, 1'b0, 1'b0, 2'b01));
    chk(!s2_pd && s2_cp_hiz, "R9 side-2 wakes, pump follows latched three-state", {s2_pd, s2_cp_hiz}, 2'b01);

    hold(10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule